// File: doc/BRIEF.md
# Serial Receive Buffer Status Logic

This block sits between a serial receiver's shift register and a CPU register bus. It holds the received-byte register and two status flags: buffer-full and overrun. When the receiver signals the end of a frame, the block decides what happens. A clean frame with the receiver enabled and the buffer empty is loaded and the buffer is marked full. A frame that ends with an error is dropped. A frame that arrives while the buffer is still full is discarded, and the overrun flag is raised.

The CPU sees a status word and the data byte at two bus addresses. It can clear the buffer-full flag by reading the data byte. It can also clear either flag by writing a zero to it, but only after it has read that flag as one. Software can never set a flag. While an overrun is pending, the block blocks further reception through an inhibit output. In synchronous mode it also blocks transmission through a second inhibit output.

Top module: `rxbuf_status`

## Requirements
- R1: After reset, both flags read 0, the data byte reads 0x00, and both inhibit outputs are 0.
- R2: The status word has buffer-full at bit 6 and overrun at bit 5, and every other bit reads 0. The status word is at address STAT_ADDR (default 0) and the data byte at DATA_ADDR (default 1). A frame-done pulse with rx enabled, no error, buffer empty and no overrun loads the byte and sets buffer-full on the next clock.
- R3: A frame that ends with the error input high does not change the data byte or buffer-full.
- R4: A frame-done pulse while rx enable is low changes nothing: the data byte and both flags keep their values.
- R5: A frame that completes while buffer-full is 1 sets the overrun flag, whether or not it carries an error. The data byte keeps the earlier value and buffer-full stays 1.
- R6: While overrun is 1, frames are ignored and rx_inhibit_o is 1. tx_inhibit_o is 1 only when sync_mode_i is also 1.
- R7: A bus read of the data address returns the byte and clears buffer-full on that clock.
- R8: A status write with a flag's bit at 0 clears that flag only if the flag was read as 1 since it last became 1. A write of 0 with no such read, or after the flag was cleared and set again, has no effect.
- R9: A status write with a flag's bit at 1 leaves the flag unchanged, so software cannot set a flag.
- R10: When a loading frame and a clearing data read fall on the same clock, the read returns the old byte and buffer-full ends up 1, holding the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| frame_done_i | input | 1 | One-cycle pulse at frame end from the shift register |
| frame_err_i | input | 1 | Frame ended with a receive error |
| frame_byte_i | input | 8 | Byte assembled by the shift register |
| rx_en_i | input | 1 | Receiver enable |
| sync_mode_i | input | 1 | Synchronous mode selected |
| bus_addr_i | input | ADDR_W | Register address |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid while bus_rd_i is high |
| rx_inhibit_o | output | 1 | Blocks further reception |
| tx_inhibit_o | output | 1 | Blocks transmission in synchronous mode |

## Verification
Some properties are checked on every cycle: a flag never rises without a set event; a blind write of 0 leaves a flag alone; a set always wins over a clear; the data byte stays frozen for error frames, disabled frames, overrun frames and while overrun is pending; and the transmit inhibit implies the receive inhibit. Only the bench's scenarios can show the rest. These are the bit positions in the status word, the read-then-write clearing sequence, and the loss of arming once a flag is cleared by a data read and set again. They also include the read value on a same-clock load, and recovery from overrun followed by a reset in the middle of a run.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
    localparam int unsigned BUS_W     = 8;
    localparam int unsigned NUM_FLAGS = 2;
    localparam int unsigned FLAG_FULL = 0;
    localparam int unsigned FLAG_OVR  = 1;
    localparam int unsigned FULL_BIT  = 6;
    localparam int unsigned OVR_BIT   = 5;

    // Bit position of each flag inside the status word.
    function automatic int unsigned flag_pos(input int unsigned idx);
        return (idx == FLAG_FULL) ? FULL_BIT : OVR_BIT;
    endfunction

    typedef struct packed {
        logic flag;
        logic armed;
    } flag_state_t;
endpackage

// File: rtl/rxbuf_flag_cell.sv
module rxbuf_flag_cell (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic stat_rd_i,
    input  logic wr_zero_i,
    input  logic drop_i,
    output logic flag_o
);
    import rxbuf_pkg::*;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_zero_i && st_q.armed) begin
            st_d.flag  = 1'b0;
            st_d.armed = 1'b0;
        end
        if (drop_i) begin
            st_d.flag = 1'b0;
        end
        if (set_i) begin
            st_d.flag = 1'b1;
        end
        if (stat_rd_i && st_q.flag) begin
            st_d.armed = 1'b1;
        end
        if (!st_d.flag) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    // R8
    no_blind_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_zero_i && !st_q.armed && !drop_i && !set_i) |=> (flag_o == $past(flag_o)));

    // R9
    no_sw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!set_i && !flag_o) |=> !flag_o);

    // R10
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i |=> flag_o);
endmodule

// File: rtl/rxbuf_frame_ctl.sv
module rxbuf_frame_ctl #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              frame_done_i,
    input  logic              frame_err_i,
    input  logic [DATA_W-1:0] frame_byte_i,
    input  logic              rx_en_i,
    input  logic              full_i,
    input  logic              ovr_i,
    output logic              set_full_o,
    output logic              set_ovr_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
    } frame_state_t;

    frame_state_t st_d, st_q;
    logic accept, load;

    always_comb begin
        accept = frame_done_i && rx_en_i && !ovr_i;
        load   = accept && !frame_err_i && !full_i;
        st_d   = st_q;
        if (load) begin
            st_d.data = frame_byte_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign set_full_o = load;
    assign set_ovr_o  = accept && full_i;
    assign data_o     = st_q.data;

    // R5
    ovr_keeps_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_done_i && full_i) |=> $stable(data_o));

    // R3
    err_keeps_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_done_i && frame_err_i) |=> $stable(data_o));

    // R4
    off_keeps_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rx_en_i |=> $stable(data_o));

    // R6
    ovr_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovr_i |=> $stable(data_o));
endmodule

// File: rtl/rxbuf_bus_dec.sv
module rxbuf_bus_dec #(
    parameter int unsigned ADDR_W = 4,
    parameter logic [ADDR_W-1:0] STAT_ADDR = '0,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 1
) (
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic                              rd_i,
    input  logic                              wr_i,
    input  logic [rxbuf_pkg::BUS_W-1:0]       wdata_i,
    input  logic [rxbuf_pkg::NUM_FLAGS-1:0]   flags_i,
    input  logic [rxbuf_pkg::BUS_W-1:0]       data_i,
    output logic                              stat_rd_o,
    output logic                              data_rd_o,
    output logic [rxbuf_pkg::NUM_FLAGS-1:0]   wr_zero_o,
    output logic [rxbuf_pkg::BUS_W-1:0]       rdata_o
);
    import rxbuf_pkg::*;

    logic [BUS_W-1:0] stat_word;
    logic stat_hit, data_hit;
    logic unused_wbits;

    always_comb begin
        stat_hit  = (addr_i == STAT_ADDR);
        data_hit  = (addr_i == DATA_ADDR);
        stat_word = '0;
        wr_zero_o = '0;
        for (int i = 0; i < int'(NUM_FLAGS); i++) begin
            stat_word[flag_pos(i)] = flags_i[i];
            wr_zero_o[i] = wr_i && stat_hit && !wdata_i[flag_pos(i)];
        end
        stat_rd_o = rd_i && stat_hit;
        data_rd_o = rd_i && data_hit;
        if (stat_rd_o) begin
            rdata_o = stat_word;
        end else if (data_rd_o) begin
            rdata_o = data_i;
        end else begin
            rdata_o = '0;
        end
    end

    assign unused_wbits = ^wdata_i;
endmodule

// File: rtl/rxbuf_status.sv
module rxbuf_status #(
    parameter int unsigned ADDR_W = 4,
    parameter logic [ADDR_W-1:0] STAT_ADDR = '0,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              frame_done_i,
    input  logic              frame_err_i,
    input  logic [7:0]        frame_byte_i,
    input  logic              rx_en_i,
    input  logic              sync_mode_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    output logic              rx_inhibit_o,
    output logic              tx_inhibit_o
);
    import rxbuf_pkg::*;

    logic [NUM_FLAGS-1:0] flag_vec, set_vec, wrz_vec, drop_vec;
    logic                 stat_rd, data_rd;
    logic [BUS_W-1:0]     data_w;
    logic                 set_full, set_ovr;

    rxbuf_bus_dec #(
        .ADDR_W    (ADDR_W),
        .STAT_ADDR (STAT_ADDR),
        .DATA_ADDR (DATA_ADDR)
    ) dec_i (
        .addr_i    (bus_addr_i),
        .rd_i      (bus_rd_i),
        .wr_i      (bus_wr_i),
        .wdata_i   (bus_wdata_i),
        .flags_i   (flag_vec),
        .data_i    (data_w),
        .stat_rd_o (stat_rd),
        .data_rd_o (data_rd),
        .wr_zero_o (wrz_vec),
        .rdata_o   (bus_rdata_o)
    );

    rxbuf_frame_ctl #(.DATA_W(BUS_W)) frm_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .frame_done_i (frame_done_i),
        .frame_err_i  (frame_err_i),
        .frame_byte_i (frame_byte_i),
        .rx_en_i      (rx_en_i),
        .full_i       (flag_vec[FLAG_FULL]),
        .ovr_i        (flag_vec[FLAG_OVR]),
        .set_full_o   (set_full),
        .set_ovr_o    (set_ovr),
        .data_o       (data_w)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        if (g == FLAG_FULL) begin : g_full
            assign set_vec[g]  = set_full;
            assign drop_vec[g] = data_rd;
        end else begin : g_ovr
            assign set_vec[g]  = set_ovr;
            assign drop_vec[g] = 1'b0;
        end
        rxbuf_flag_cell cell_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .set_i     (set_vec[g]),
            .stat_rd_i (stat_rd),
            .wr_zero_i (wrz_vec[g]),
            .drop_i    (drop_vec[g]),
            .flag_o    (flag_vec[g])
        );
    end

    assign rx_inhibit_o = flag_vec[FLAG_OVR];
    assign tx_inhibit_o = flag_vec[FLAG_OVR] && sync_mode_i;

    // R6
    tx_needs_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_inhibit_o |-> rx_inhibit_o);

    // R6
    inhibit_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_inhibit_o && frame_done_i) |=> $stable(data_w));

    // R5
    ovr_needs_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_ovr && !data_rd) |=> (flag_vec[FLAG_FULL] && flag_vec[FLAG_OVR]));
endmodule

// File: tb/rxbuf_status_tb_top.sv
`timescale 1ns/1ps
module rxbuf_status_tb_top;
    localparam logic [1:0] OP_FR = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2, OP_ID = 2'd3;
    localparam logic A_ST = 1'b0, A_DT = 1'b1;

    typedef struct packed {
        logic [1:0] op;
        logic       adr;
        logic       err;
        logic       en;
        logic       sync;
        logic [7:0] dat;
        logic [7:0] exp;
        logic [1:0] inh;   // {tx, rx}
        logic [3:0] req;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t TBL [NV] = '{
        '{OP_RD, A_ST, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 2'b00, 4'd1},  // R1
        '{OP_RD, A_DT, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 2'b00, 4'd1},  // R1
        '{OP_ID, A_ST, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 2'b00, 4'd1},  // R1
        '{OP_FR, A_ST, 1'b0, 1'b1, 1'b0, 8'hA5, 8'h00, 2'b00, 4'd2},  // R2
        '{OP_RD, A_ST, 1'b0, 1'b1, 1'b0, 8'h00, 8'h40, 2'b00, 4'd2},  // R2
        '{OP_RD, A_DT, 1'b0, 1'b1, 1'b0, 8'h00, 8'hA5, 2'b00, 4'd7},  // R7
        '{OP_RD, A_ST, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 2'b00, 4'd7},  // R7
        '{OP_FR, A_ST, 1'b1, 1'b1, 1'b0, 8'h3C, 8'h00, 2'b00, 4'd3},  // R3
        '{OP_RD, A_ST, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 2'b00, 4'd3},  // R3
        '{OP_RD, A_DT, 1'b0, 1'b1, 1'b0, 8'h00, 8'hA5, 2'b00, 4'd3},  // R3
        '{OP_FR, A_ST, 1'b0, 1'b0, 1'b0, 8'h77, 8'h00, 2'b00, 4'd4},  // R4
        '{OP_RD, A_ST, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 2'b00, 4'd4},  // R4
        '{OP_RD, A_DT, 1'b0, 1'b1, 1'b0, 8'h00, 8'hA5, 2'b00, 4'd4},  // R4
        '{OP_FR, A_ST, 1'b0, 1'b1, 1'b0, 8'h11, 8'h00, 2'b00, 4'd8},  // R8
        '{OP_WR, A_ST, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 2'b00, 4'd8},  // R8 blind write
        '{OP_RD, A_ST, 1'b0, 1'b1, 1'b0, 8'h00, 8'h40, 2'b00, 4'd8},  // R8
        '{OP_WR, A_ST, 1'b0, 1'b1, 1'b0, 8'hFF, 8'h00, 2'b00, 4'd9},  // R9
        '{OP_RD, A_ST, 1'b0, 1'b1, 1'b0, 8'h00, 8'h40, 2'b00, 4'd9},  // R9
        '{OP_WR, A_ST, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 2'b00, 4'd8},  // R8 clear
        '{OP_RD, A_ST, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 2'b00, 4'd8},  // R8
        '{OP_RD, A_DT, 1'b0, 1'b1, 1'b0, 8'h00, 8'h11, 2'b00, 4'd8},  // R8
        '{OP_FR, A_ST, 1'b0, 1'b1, 1'b0, 8'h22, 8'h00, 2'b00, 4'd5},  // R5
        '{OP_FR, A_ST, 1'b0, 1'b1, 1'b0, 8'h33, 8'h00, 2'b00, 4'd5},  // R5
        '{OP_RD, A_ST, 1'b0, 1'b1, 1'b0, 8'h00, 8'h60, 2'b00, 4'd5},  // R5
        '{OP_RD, A_DT, 1'b0, 1'b1, 1'b0, 8'h00, 8'h22, 2'b00, 4'd5},  // R5
        '{OP_ID, A_ST, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 2'b01, 4'd6},  // R6
        '{OP_ID, A_ST, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 2'b11, 4'd6},  // R6
        '{OP_FR, A_ST, 1'b0, 1'b1, 1'b0, 8'h44, 8'h00, 2'b00, 4'd6},  // R6
        '{OP_RD, A_ST, 1'b0, 1'b1, 1'b0, 8'h00, 8'h20, 2'b00, 4'd6},  // R6
        '{OP_RD, A_DT, 1'b0, 1'b1, 1'b0, 8'h00, 8'h22, 2'b00, 4'd6},  // R6
        '{OP_WR, A_ST, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 2'b00, 4'd8},  // R8
        '{OP_RD, A_ST, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 2'b00, 4'd8},  // R8
        '{OP_ID, A_ST, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 2'b00, 4'd6}   // R6
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_done = 1'b0, frame_err = 1'b0, rx_en = 1'b0, sync_mode = 1'b0;
    logic [7:0] frame_byte = '0;
    logic [3:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_inh, tx_inh;

    int n_cmp = 0;
    int n_bad = 0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    rxbuf_status dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .frame_done_i (frame_done),
        .frame_err_i  (frame_err),
        .frame_byte_i (frame_byte),
        .rx_en_i      (rx_en),
        .sync_mode_i  (sync_mode),
        .bus_addr_i   (bus_addr),
        .bus_rd_i     (bus_rd),
        .bus_wr_i     (bus_wr),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .rx_inhibit_o (rx_inh),
        .tx_inhibit_o (tx_inh)
    );

    task automatic check(input logic ok, input int req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One bus/frame operation: drive after a falling edge, sample, let the rising edge act.
    task automatic step(input vec_t v);
        @(negedge clk);
        frame_done = (v.op == OP_FR);
        frame_err  = v.err;
        frame_byte = (v.op == OP_FR) ? v.dat : 8'h00;
        rx_en      = v.en;
        sync_mode  = v.sync;
        bus_addr   = {3'b000, v.adr};
        bus_rd     = (v.op == OP_RD);
        bus_wr     = (v.op == OP_WR);
        bus_wdata  = v.dat;
        #1;
        if (v.op == OP_RD) check(bus_rdata == v.exp, int'(v.req), bus_rdata, v.exp);
        if (v.op == OP_ID) check({tx_inh, rx_inh} == v.inh, int'(v.req), {6'd0, tx_inh, rx_inh}, {6'd0, v.inh});
        @(posedge clk);
    endtask

    function automatic vec_t mk(input logic [1:0] op, input logic adr, input logic err,
                                input logic [7:0] dat, input logic [7:0] exp, input logic [3:0] req);
        return '{op, adr, err, 1'b1, 1'b0, dat, exp, 2'b00, req};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) step(TBL[i]);

        // R10: loading frame and data read on the same clock; read sees old byte 0x22
        @(negedge clk);
        frame_done = 1'b1; frame_err = 1'b0; frame_byte = 8'h66; rx_en = 1'b1;
        bus_addr = 4'd1; bus_rd = 1'b1; bus_wr = 1'b0;
        #1 check(bus_rdata == 8'h22, 10, bus_rdata, 8'h22);   // R10
        @(posedge clk);
        step(mk(OP_RD, A_ST, 1'b0, 8'h00, 8'h40, 4'd10));     // R10
        step(mk(OP_RD, A_DT, 1'b0, 8'h00, 8'h66, 4'd10));     // R10
        step(mk(OP_RD, A_ST, 1'b0, 8'h00, 8'h00, 4'd7));      // R7

        // R8: arming is lost when the flag is cleared by a data read and set again
        step(mk(OP_FR, A_ST, 1'b0, 8'h77, 8'h00, 4'd8));
        step(mk(OP_RD, A_ST, 1'b0, 8'h00, 8'h40, 4'd8));
        step(mk(OP_RD, A_DT, 1'b0, 8'h00, 8'h77, 4'd8));
        step(mk(OP_FR, A_ST, 1'b0, 8'h78, 8'h00, 4'd8));
        step(mk(OP_WR, A_ST, 1'b0, 8'h00, 8'h00, 4'd8));
        step(mk(OP_RD, A_ST, 1'b0, 8'h00, 8'h40, 4'd8));      // R8 still full

        // R5: error frame while full still raises overrun
        step(mk(OP_FR, A_ST, 1'b1, 8'h99, 8'h00, 4'd5));
        step(mk(OP_RD, A_ST, 1'b0, 8'h00, 8'h60, 4'd5));      // R5
        step(mk(OP_RD, A_DT, 1'b0, 8'h00, 8'h78, 4'd5));      // R5
        step(mk(OP_WR, A_ST, 1'b0, 8'h00, 8'h00, 4'd8));      // R8 clears armed overrun
        step(mk(OP_RD, A_ST, 1'b0, 8'h00, 8'h00, 4'd8));

        // R1: reset in the middle of a run
        step(mk(OP_FR, A_ST, 1'b0, 8'hAB, 8'h00, 4'd1));
        @(negedge clk);
        frame_done = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step(mk(OP_RD, A_ST, 1'b0, 8'h00, 8'h00, 4'd1));      // R1
        step(mk(OP_RD, A_DT, 1'b0, 8'h00, 8'h00, 4'd1));      // R1
        step('{OP_ID, A_ST, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 2'b00, 4'd1}); // R1

        @(negedge clk);
        frame_done = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule